// File: doc/BRIEF.md
# Multi-hart machine timer unit

This block keeps one 64-bit time counter shared by a group of harts, plus a 64-bit compare register for every hart. Each hart gets its own level-sensitive timer interrupt line, which is high while that hart's compare value has been reached by the counter. Software running on either 32-bit or 64-bit cores reaches the counter and all compare registers through a small register bus. A 32-bit core can update one half of a register without disturbing the other half.

The counter advances by one on every clock in which the `tick_en` input is high. The tick is expected to arrive already synchronous to `clk`. A bus write to the counter replaces the counter value outright. Every interrupt line is derived directly from the stored registers, so any counter or compare write shows up on all interrupt lines in the cycle after the write.

Top module: `hart_timer_unit`

## Requirements
- R1: `irq[i]` is high exactly when compare register i is less than or equal to the time counter, using an unsigned 64-bit comparison. A compare write changes `irq[i]` in the cycle directly after the write edge.
- R2: The compare register of hart i is at `CMP_BASE + 8*i`. An 8-byte access (`size`=1) at offset 0 reads or writes all 64 bits. A 4-byte access (`size`=0) at offset 0 reads the low half into `rdata[31:0]`. A read of either size at offset 4 returns the high half in `rdata[31:0]`. All unused `rdata` bits read as zero.
- R3: A 4-byte write to one half of a compare register, taken from `wdata[31:0]`, leaves the other half unchanged.
- R4: The time counter is at `TIME_BASE`, with the same half layout and read formats as a compare register. An 8-byte write at offset 0 loads all 64 bits.
- R5: A 4-byte write to one half of the time counter replaces only that half and keeps the other half.
- R6: A synchronous reset (`rst_n` low) clears the time counter and `rdata` to zero. Compare registers have no reset value.
- R7: The counter adds one on each cycle in which `tick_en` is high, carrying across the 32-bit boundary. A counter write in the same cycle wins over the increment.
- R8: An 8-byte write at offset 4 of the counter or of any compare register changes nothing.
- R9: A read of an unmapped address returns zero. A write to an unmapped address changes nothing. Unmapped addresses are: compare slots at or beyond `NUM_HARTS`, any address with `addr[1:0]` not zero, and any address outside both regions.
- R10: `rdata` is registered. It updates at the clock edge that accepts a read (`req`=1, `we`=0) and holds its value at all other times.
- R11: A write to either half of the time counter re-evaluates the interrupt line of every hart against the new counter value in the next cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_en | input | 1 | Counter advance enable, one increment per high cycle |
| req | input | 1 | Bus access valid this cycle |
| we | input | 1 | 1 = write, 0 = read |
| addr | input | ADDR_W | Byte address of the access |
| wdata | input | 64 | Write data, little-endian; 4-byte writes use bits 31:0 |
| size | input | 1 | 0 = 4-byte access, 1 = 8-byte access |
| rdata | output | 64 | Registered read data |
| irq | output | NUM_HARTS | Per-hart timer interrupt level |

## Verification
A counter write and a tick increment can land in the same cycle. The bench provokes this by holding `tick_en` high across both a full 64-bit counter write and a low-half counter write. It then reads the counter with ticking stopped and requires exactly the written value, with no extra increment added. A second meeting point is a counter half write that pushes the counter past several compare values in one step. The bench judges this on all interrupt lines in the very next cycle, including a compare value that differs from the counter only in its high half.

// File: rtl/htu_pkg.sv
// Shared types and helpers for the multi-hart timer unit.
// Assumes 64-bit registers split into two 32-bit halves.
package htu_pkg;

    localparam int unsigned WORD_W = 64;
    localparam int unsigned HALF_W = 32;

    // Source selected for a read response
    typedef enum logic [1:0] {
        RD_NONE = 2'd0,
        RD_CMP  = 2'd1,
        RD_TIME = 2'd2
    } rd_src_e;

    // Per-register half write enables
    typedef struct packed {
        logic hi;
        logic lo;
    } half_we_t;

    // Replace the enabled halves of a 64-bit word, keep the rest
    function automatic logic [WORD_W-1:0] merge_halves(
        input logic [WORD_W-1:0] cur,
        input half_we_t          en,
        input logic [HALF_W-1:0] lo_d,
        input logic [HALF_W-1:0] hi_d
    );
        merge_halves = {en.hi ? hi_d : cur[WORD_W-1:HALF_W],
                        en.lo ? lo_d : cur[HALF_W-1:0]};
    endfunction

endpackage

// File: rtl/htu_decode.sv
// Address decoder for the timer unit.
// Maps a bus access onto half write enables for the counter and each compare
// slot, and steers the write data into low and high half values.
// It also names the read source and read format.
// Assumes: CMP_BASE and TIME_BASE are 8-byte aligned and the two regions do
// not overlap. An 8-byte write at offset 4 enables nothing.
module htu_decode
    import htu_pkg::*;
#(
    parameter int unsigned          NUM_HARTS = 4,
    parameter int unsigned          ADDR_W    = 16,
    parameter logic [ADDR_W-1:0]    CMP_BASE  = '0,
    parameter logic [ADDR_W-1:0]    TIME_BASE = ADDR_W'(16'h0100),
    parameter int unsigned          IDX_W     = 2
) (
    input  logic                    req,
    input  logic                    we,
    input  logic [ADDR_W-1:0]       addr,
    input  logic                    wide,
    input  logic [WORD_W-1:0]       wdata,
    output half_we_t [NUM_HARTS-1:0] cmp_we,
    output half_we_t                time_we,
    output logic [HALF_W-1:0]       wr_lo,
    output logic [HALF_W-1:0]       wr_hi,
    output logic                    rd_en,
    output rd_src_e                 rd_src,
    output logic [IDX_W-1:0]        rd_idx,
    output logic                    rd_hi,
    output logic                    rd_wide,
    output logic                    rd_unmapped
);

    localparam logic [ADDR_W-1:0] CMP_SPAN = ADDR_W'(8 * NUM_HARTS);

    logic              word_ok;
    logic              hi_off;
    logic              in_cmp;
    logic              in_time;
    logic [ADDR_W-1:0] cmp_off;
    logic [IDX_W-1:0]  hart_idx;
    logic              wr;
    logic              lo_hit;
    logic              hi_hit;

    assign word_ok  = (addr[1:0] == 2'b00);
    assign hi_off   = addr[2];
    assign cmp_off  = addr - CMP_BASE;
    assign in_cmp   = word_ok && (cmp_off < CMP_SPAN);
    assign in_time  = word_ok && (addr[ADDR_W-1:3] == TIME_BASE[ADDR_W-1:3]);
    assign hart_idx = cmp_off[IDX_W+2:3];

    // Which halves a write touches: the low half only at offset 0, the high
    // half by a 4-byte write at offset 4 or an 8-byte write at offset 0
    always_comb begin : p_half_sel
        wr     = req && we;
        lo_hit = wr && !hi_off;
        hi_hit = wr && (hi_off ? !wide : wide);
    end

    // Steer write data: an 8-byte write carries the high half in bits 63:32
    always_comb begin : p_data_steer
        wr_lo = wdata[HALF_W-1:0];
        wr_hi = wide ? wdata[WORD_W-1:HALF_W] : wdata[HALF_W-1:0];
    end

    // Per-slot and counter write enables
    always_comb begin : p_wr_enables
        for (int h = 0; h < NUM_HARTS; h++) begin
            cmp_we[h].lo = lo_hit && in_cmp && (hart_idx == IDX_W'(h));
            cmp_we[h].hi = hi_hit && in_cmp && (hart_idx == IDX_W'(h));
        end
        time_we.lo = lo_hit && in_time;
        time_we.hi = hi_hit && in_time;
    end

    // Read source and format
    always_comb begin : p_rd_decode
        rd_en   = req && !we;
        rd_idx  = hart_idx;
        rd_hi   = hi_off;
        rd_wide = wide;
        if (in_cmp) begin
            rd_src = RD_CMP;
        end else if (in_time) begin
            rd_src = RD_TIME;
        end else begin
            rd_src = RD_NONE;
        end
        rd_unmapped = rd_en && (rd_src == RD_NONE);
    end

endmodule

// File: rtl/htu_time_counter.sv
// Shared 64-bit time counter.
// Clears on synchronous reset and loads the enabled halves on a bus write.
// Otherwise it adds one when tick_en is high.
// Assumes tick_en is already synchronous to clk.
module htu_time_counter
    import htu_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_en,
    input  half_we_t          we,
    input  logic [HALF_W-1:0] lo_d,
    input  logic [HALF_W-1:0] hi_d,
    output logic [WORD_W-1:0] time_o
);

    logic [WORD_W-1:0] time_q;

    // Counter register: reset, bus write (wins over tick), then increment
    always_ff @(posedge clk) begin : p_count
        if (!rst_n) begin
            time_q <= '0;
        end else if (we.lo || we.hi) begin
            time_q <= merge_halves(time_q, we, lo_d, hi_d);
        end else if (tick_en) begin
            time_q <= time_q + WORD_W'(1);
        end
    end

    assign time_o = time_q;

endmodule

// File: rtl/htu_cmp_slot.sv
// One hart's compare register and its interrupt comparator.
// The register has no reset, so its value is undefined until software
// writes it. The interrupt is a direct unsigned comparison of stored
// registers, with no added register stage.
module htu_cmp_slot
    import htu_pkg::*;
(
    input  logic              clk,
    input  half_we_t          we,
    input  logic [HALF_W-1:0] lo_d,
    input  logic [HALF_W-1:0] hi_d,
    input  logic [WORD_W-1:0] time_i,
    output logic [WORD_W-1:0] cmp_o,
    output logic              irq_o
);

    logic [WORD_W-1:0] cmp_q;

    // Compare register: merge the written halves with the kept ones
    always_ff @(posedge clk) begin : p_cmp_store
        if (we.lo || we.hi) begin
            cmp_q <= merge_halves(cmp_q, we, lo_d, hi_d);
        end
    end

    // Level interrupt: deadline reached when compare <= time
    always_comb begin : p_cmp_level
        irq_o = (cmp_q <= time_i);
    end

    assign cmp_o = cmp_q;

endmodule

// File: rtl/hart_timer_unit.sv
// Top of the multi-hart timer unit.
// Connects the decoder, the shared counter and one compare slot per hart,
// and registers the read response.
// Assumes: NUM_HARTS from 1 to 16, and single-cycle accesses with no stall.
module hart_timer_unit
    import htu_pkg::*;
#(
    parameter int unsigned       NUM_HARTS = 4,
    parameter int unsigned       ADDR_W    = 16,
    parameter logic [ADDR_W-1:0] CMP_BASE  = '0,
    parameter logic [ADDR_W-1:0] TIME_BASE = ADDR_W'(16'h0100)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 tick_en,
    input  logic                 req,
    input  logic                 we,
    input  logic [ADDR_W-1:0]    addr,
    input  logic [63:0]          wdata,
    input  logic                 size,
    output logic [63:0]          rdata,
    output logic [NUM_HARTS-1:0] irq
);

    localparam int unsigned IDX_W = (NUM_HARTS > 1) ? $clog2(NUM_HARTS) : 1;

    half_we_t [NUM_HARTS-1:0] cmp_we;
    half_we_t                 time_we;
    logic [HALF_W-1:0]        wr_lo;
    logic [HALF_W-1:0]        wr_hi;
    logic                     rd_en;
    rd_src_e                  rd_src;
    logic [IDX_W-1:0]         rd_idx;
    logic                     rd_hi;
    logic                     rd_wide;
    logic                     rd_unmapped;
    logic [WORD_W-1:0]        time_now;
    logic [WORD_W-1:0]        cmp_val [NUM_HARTS];
    logic [WORD_W-1:0]        sel_word;
    logic [WORD_W-1:0]        rd_word;

    htu_decode #(
        .NUM_HARTS (NUM_HARTS),
        .ADDR_W    (ADDR_W),
        .CMP_BASE  (CMP_BASE),
        .TIME_BASE (TIME_BASE),
        .IDX_W     (IDX_W)
    ) u_decode (
        .req         (req),
        .we          (we),
        .addr        (addr),
        .wide        (size),
        .wdata       (wdata),
        .cmp_we      (cmp_we),
        .time_we     (time_we),
        .wr_lo       (wr_lo),
        .wr_hi       (wr_hi),
        .rd_en       (rd_en),
        .rd_src      (rd_src),
        .rd_idx      (rd_idx),
        .rd_hi       (rd_hi),
        .rd_wide     (rd_wide),
        .rd_unmapped (rd_unmapped)
    );

    htu_time_counter u_time (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick_en (tick_en),
        .we      (time_we),
        .lo_d    (wr_lo),
        .hi_d    (wr_hi),
        .time_o  (time_now)
    );

    for (genvar h = 0; h < NUM_HARTS; h++) begin : g_hart
        htu_cmp_slot u_slot (
            .clk    (clk),
            .we     (cmp_we[h]),
            .lo_d   (wr_lo),
            .hi_d   (wr_hi),
            .time_i (time_now),
            .cmp_o  (cmp_val[h]),
            .irq_o  (irq[h])
        );
    end

    // Pick the addressed 64-bit register; unmapped selects zero
    always_comb begin : p_rd_pick
        sel_word = '0;
        if (rd_src == RD_TIME) begin
            sel_word = time_now;
        end else if (rd_src == RD_CMP) begin
            for (int h = 0; h < NUM_HARTS; h++) begin
                if (rd_idx == IDX_W'(h)) begin
                    sel_word = cmp_val[h];
                end
            end
        end
    end

    // Shape the response: high half or low half into bits 31:0, or full word
    always_comb begin : p_rd_shape
        if (rd_hi) begin
            rd_word = {{HALF_W{1'b0}}, sel_word[WORD_W-1:HALF_W]};
        end else if (rd_wide) begin
            rd_word = sel_word;
        end else begin
            rd_word = {{HALF_W{1'b0}}, sel_word[HALF_W-1:0]};
        end
    end

    // Registered read data, updated only by an accepted read
    always_ff @(posedge clk) begin : p_rd_reg
        if (!rst_n) begin
            rdata <= '0;
        end else if (rd_en) begin
            rdata <= rd_word;
        end
    end

endmodule

// File: rtl/htu_checker.sv
// Property checker for the timer unit, attached by bind.
// It watches the bus, the tick, the counter, the read data and the
// interrupt lines.
module htu_checker #(
    parameter int unsigned       NUM_HARTS = 4,
    parameter int unsigned       ADDR_W    = 16,
    parameter logic [ADDR_W-1:0] TIME_BASE = ADDR_W'(16'h0100)
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 tick_en,
    input logic                 req,
    input logic                 we,
    input logic [ADDR_W-1:0]    addr,
    input logic                 size,
    input logic [63:0]          time_q,
    input logic                 time_wr,
    input logic                 rd_unmapped,
    input logic [63:0]          rdata,
    input logic [NUM_HARTS-1:0] irq
);

    localparam logic [ADDR_W-1:0] TIME_HI = TIME_BASE + ADDR_W'(4);

    // R6: reset clears the counter
    p_time_clear_r6: assert property (@(posedge clk)
        !rst_n |=> (time_q == 64'd0));

    // R7: a tick with no counter write adds exactly one
    p_tick_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_en && !time_wr) |=> (time_q == $past(time_q) + 64'd1));

    // R7: no tick and no write leaves the counter alone
    p_idle_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick_en && !time_wr) |=> $stable(time_q));

    // R8: an 8-byte write at the counter's high offset is dropped
    p_wide_hi_drop_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (req && we && size && (addr == TIME_HI) && !tick_en) |=> $stable(time_q));

    // R1: with no write and no wrap, a raised interrupt stays raised
    p_irq_sticky_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (!(req && we) && (time_q != '1)) |=> ((irq & $past(irq)) == $past(irq)));

    // R10: read data holds when no read is accepted
    p_rdata_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !(req && !we) |=> $stable(rdata));

    // R9: an unmapped read returns zero
    p_unmapped_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
        rd_unmapped |=> (rdata == 64'd0));

endmodule

bind hart_timer_unit htu_checker #(
    .NUM_HARTS (NUM_HARTS),
    .ADDR_W    (ADDR_W),
    .TIME_BASE (TIME_BASE)
) u_htu_checker (
    .clk         (clk),
    .rst_n       (rst_n),
    .tick_en     (tick_en),
    .req         (req),
    .we          (we),
    .addr        (addr),
    .size        (size),
    .time_q      (time_now),
    .time_wr     (time_we.lo | time_we.hi),
    .rd_unmapped (rd_unmapped),
    .rdata       (rdata),
    .irq         (irq)
);

// File: tb/hart_timer_unit_tb_top.sv
// Directed bench for the timer unit: one task per scenario, each self-checked.
module hart_timer_unit_tb_top;

    localparam int unsigned NH = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          tick_en = 1'b0;
    logic          req = 1'b0;
    logic          we = 1'b0;
    logic [15:0]   addr = '0;
    logic [63:0]   wdata = '0;
    logic          size = 1'b0;
    logic [63:0]   rdata;
    logic [NH-1:0] irq;

    int n_chk = 0;
    int n_bad = 0;

    localparam logic [15:0] TB = 16'h0100;

    always #2 clk = ~clk;

    hart_timer_unit #(.NUM_HARTS(NH)) dut_i (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .req(req), .we(we),
        .addr(addr), .wdata(wdata), .size(size), .rdata(rdata), .irq(irq)
    );

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [15:0] a, input logic [63:0] d, input logic w);
        req = 1'b1; we = 1'b1; addr = a; wdata = d; size = w;
        @(posedge clk);
        @(negedge clk);
        req = 1'b0; we = 1'b0;
    endtask

    task automatic rd(input logic [15:0] a, input logic w, output logic [63:0] d);
        req = 1'b1; we = 1'b0; addr = a; size = w;
        @(posedge clk);
        @(negedge clk);
        req = 1'b0;
        d = rdata;
    endtask

    function automatic logic [15:0] ca(input int h);
        return 16'(8 * h);
    endfunction

    task automatic t_reset();
        logic [63:0] v;
        chk("R6 rdata after reset", rdata, 64'd0);
        rd(TB, 1'b1, v);
        chk("R6 time after reset", v, 64'd0);
    endtask

    task automatic t_cmp_map();
        logic [63:0] v;
        for (int h = 0; h < NH; h++) begin
            wr(ca(h), 64'h0123_4567_89AB_CDE0 + 64'(h) * 64'h0000_0001_0000_0001, 1'b1);
        end
        for (int h = 0; h < NH; h++) begin
            rd(ca(h), 1'b1, v);
            chk("R2 full compare read", v, 64'h0123_4567_89AB_CDE0 + 64'(h) * 64'h0000_0001_0000_0001);
        end
        rd(ca(2) + 16'd4, 1'b0, v);
        chk("R2 high half 4-byte read", v, 64'h0000_0000_0123_4569);
        rd(ca(2), 1'b0, v);
        chk("R2 low half 4-byte read", v, 64'h0000_0000_89AB_CDE2);
        rd(ca(2) + 16'd4, 1'b1, v);
        chk("R2 high half 8-byte read", v, 64'h0000_0000_0123_4569);
    endtask

    task automatic t_cmp_merge();
        logic [63:0] v;
        wr(ca(1), 64'h1111_2222_3333_4444, 1'b1);
        wr(ca(1), 64'hDEAD_BEEF_AAAA_BBBB, 1'b0);
        rd(ca(1), 1'b1, v);
        chk("R3 low half write keeps high", v, 64'h1111_2222_AAAA_BBBB);
        wr(ca(1) + 16'd4, 64'hFEED_FACE_0000_5555, 1'b0);
        rd(ca(1), 1'b1, v);
        chk("R3 high half write keeps low", v, 64'h0000_5555_AAAA_BBBB);
    endtask

    task automatic t_time_rw();
        logic [63:0] v;
        wr(TB, 64'h0000_0001_FFFF_FFF0, 1'b1);
        rd(TB, 1'b1, v);
        chk("R4 full counter read", v, 64'h0000_0001_FFFF_FFF0);
        wr(TB, 64'hCAFE_0000_0000_0010, 1'b0);
        rd(TB, 1'b1, v);
        chk("R5 low half counter write", v, 64'h0000_0001_0000_0010);
        wr(TB + 16'd4, 64'h0000_0000_0000_0007, 1'b0);
        rd(TB + 16'd4, 1'b0, v);
        chk("R4 counter high half read", v, 64'h0000_0000_0000_0007);
        rd(TB, 1'b0, v);
        chk("R5 high half write kept low", v, 64'h0000_0000_0000_0010);
    endtask

    task automatic t_tick();
        logic [63:0] v;
        wr(TB, 64'h0000_0000_FFFF_FFFE, 1'b1);
        tick_en = 1'b1;
        repeat (5) @(negedge clk);
        tick_en = 1'b0;
        rd(TB, 1'b1, v);
        chk("R7 five ticks with carry", v, 64'h0000_0001_0000_0003);
    endtask

    task automatic t_collide();
        logic [63:0] v;
        tick_en = 1'b1;
        wr(TB, 64'h0000_0042_0000_1000, 1'b1);
        tick_en = 1'b0;
        rd(TB, 1'b1, v);
        chk("R7 full write wins over tick", v, 64'h0000_0042_0000_1000);
        tick_en = 1'b1;
        wr(TB, 64'h0000_0000_0000_0500, 1'b0);
        tick_en = 1'b0;
        rd(TB, 1'b1, v);
        chk("R7 half write wins over tick", v, 64'h0000_0042_0000_0500);
    endtask

    task automatic t_irq();
        wr(ca(0), 64'd100, 1'b1);
        wr(ca(1), 64'd200, 1'b1);
        wr(ca(2), 64'd200, 1'b1);
        wr(ca(3), 64'h0000_0001_0000_0000, 1'b1);
        wr(TB, 64'd150, 1'b1);
        chk("R11 counter write to 150", 64'(irq), 64'b0001);
        wr(TB, 64'd200, 1'b1);
        chk("R1 equality raises", 64'(irq), 64'b0111);
        wr(TB, 64'h0000_0000_FFFF_FFFF, 1'b1);
        chk("R1 high half compare not reached", 64'(irq), 64'b0111);
        wr(TB + 16'd4, 64'd1, 1'b0);
        chk("R11 high half counter write", 64'(irq), 64'b1111);
        wr(ca(3), 64'hFFFF_FFFF_FFFF_FFFF, 1'b1);
        chk("R1 compare raised above counter", 64'(irq), 64'b0111);
        wr(TB, 64'd0, 1'b1);
        chk("R11 counter cleared by write", 64'(irq), 64'b0000);
        wr(ca(1), 64'd0, 1'b1);
        chk("R1 compare write to zero", 64'(irq), 64'b0010);
    endtask

    task automatic t_ignore();
        logic [63:0] v;
        wr(TB, 64'h0000_0005_0000_0006, 1'b1);
        wr(TB + 16'd4, 64'hAAAA_AAAA_AAAA_AAAA, 1'b1);
        rd(TB, 1'b1, v);
        chk("R8 wide write at counter +4", v, 64'h0000_0005_0000_0006);
        wr(ca(2), 64'h0000_0009_0000_0008, 1'b1);
        wr(ca(2) + 16'd4, 64'h5555_5555_5555_5555, 1'b1);
        rd(ca(2), 1'b1, v);
        chk("R8 wide write at compare +4", v, 64'h0000_0009_0000_0008);
    endtask

    task automatic t_unmapped();
        logic [63:0] v;
        rd(ca(NH), 1'b1, v);
        chk("R9 missing hart slot read", v, 64'd0);
        rd(TB, 1'b1, v);
        rd(16'h0200, 1'b1, v);
        chk("R9 outside regions read", v, 64'd0);
        rd(TB, 1'b1, v);
        rd(TB + 16'd2, 1'b0, v);
        chk("R9 misaligned read", v, 64'd0);
        wr(ca(NH), 64'hFFFF_FFFF_FFFF_FFFF, 1'b1);
        wr(TB + 16'd1, 64'hFFFF_FFFF_FFFF_FFFF, 1'b0);
        rd(ca(NH - 1), 1'b1, v);
        chk("R9 unmapped write left last slot", v, 64'hFFFF_FFFF_FFFF_FFFF);
        rd(TB, 1'b1, v);
        chk("R9 unmapped write left counter", v, 64'h0000_0005_0000_0006);
    endtask

    task automatic t_rdata_hold();
        logic [63:0] v;
        rd(ca(2), 1'b1, v);
        chk("R10 read value", v, 64'h0000_0009_0000_0008);
        wr(TB, 64'd77, 1'b1);
        repeat (3) @(negedge clk);
        chk("R10 rdata held over write and idle", rdata, 64'h0000_0009_0000_0008);
    endtask

    initial begin : main
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_cmp_map();
        t_cmp_merge();
        t_time_rw();
        t_tick();
        t_collide();
        t_irq();
        t_ignore();
        t_unmapped();
        t_rdata_hold();
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL timeout all requirements actual=hung expected=done");
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

endmodule